// File: doc/BRIEF.md
# Digital Clock Calibration Adjuster

This block trims the effective rate of a 32.768 kHz timebase without touching the crystal. It sits between the tick source, which arrives as single-cycle strobes in the fast system clock domain, and the timekeeping divider. Within each correction window of 2^WIN_BITS raw ticks it either deletes ticks or inserts extra ticks. A sign input picks which of the two it does, and an unsigned magnitude gives how many ticks per window. The corrections are spread evenly across the window instead of being bunched together.

A fast crystal (positive frequency error) is corrected by deleting ticks. A slow crystal (negative error) is corrected by inserting ticks. Each magnitude step is one tick per window, which is about 0.95 ppm with the default 2^20-tick window. That keeps the residual error well inside ±2.17 ppm.

For measurement, a calibration-enable input switches a shared output pin. Normally the pin carries the power-fail flag. In calibration mode it carries a nominal 512 Hz square wave, divided from the uncorrected ticks, which an external frequency counter can measure. Converting the measured error into ppm and into a magnitude is left to the user.

Top module: `cal_trim_top`

## Requirements
- R1: During and right after a synchronous active-low reset, `tick_out` is 0, the correction accumulator is cleared, and the reference divider is cleared, so `pin_out` is 0 when `cal_en`=1.
- R2: Each raw tick strobe sampled on `tick_in` appears on `tick_out` exactly one clock later, unless it is deleted. With `cal_mag`=0 every tick passes and no extra pulse appears.
- R3: `cal_sign`=1 selects deletion: a tick chosen for correction is masked and `tick_out` stays 0 in the cycle where it would have appeared.
- R4: `cal_sign`=0 selects insertion: a tick chosen for correction passes, and one extra single-cycle pulse follows P/2 clocks (rounded down) after it. P is the count of clocks between the two most recent raw ticks.
- R5: Even spreading: counting raw ticks from reset as n=1,2,…, tick n is chosen for correction when floor(n·M/2^WIN_BITS) > floor((n−1)·M/2^WIN_BITS), with M=`cal_mag`.
- R6: Over one window of 2^WIN_BITS raw ticks starting from reset, `tick_out` carries exactly 2^WIN_BITS−M pulses when deleting and 2^WIN_BITS+M when inserting.
- R7: With `cal_en`=0, `pin_out` equals `pf_in` in the same cycle.
- R8: With `cal_en`=1, `pin_out` is a square wave taken from the raw (uncorrected) ticks. It is 0 for the first 2^(REF_DIV_W−1) ticks after reset, 1 for the next 2^(REF_DIV_W−1), and repeats every 2^REF_DIV_W ticks (512 Hz from 32.768 kHz with the default of 6).
- R9: Every pulse on `tick_out` lasts exactly one clock when raw ticks are at least four clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the tick rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_en | input | 1 | Calibration mode: pin shows the reference square wave |
| cal_sign | input | 1 | 1 = delete ticks, 0 = insert ticks |
| cal_mag | input | MAG_W | Corrections per window |
| pf_in | input | 1 | Power-fail flag routed to the pin outside calibration mode |
| tick_in | input | 1 | Raw 32.768 kHz tick strobe, one clock wide |
| tick_out | output | 1 | Corrected tick strobe |
| pin_out | output | 1 | Shared pin: power-fail flag or reference square wave |

## Verification
The bench builds the block with WIN_BITS=6 and CNT_W=8, keeping MAG_W=5 and REF_DIV_W=6. A full 64-tick window then takes a few hundred clocks. The largest magnitude of 31 covers almost half the window, so the even-spreading rule and the exact per-window totals can be checked tick by tick for both signs. Raw ticks are ten clocks apart, which puts each inserted pulse at a known offset of five clocks. The 64-tick reference period lets a whole square-wave cycle be observed.

// File: rtl/cal_pkg.sv
// Shared types for the calibration adjuster.
// Assumes nothing beyond a synthesizable enum.
package cal_pkg;

    // Action taken on the current raw tick.
    typedef enum logic [1:0] {
        ACT_PASS = 2'd0,
        ACT_DROP = 2'd1,
        ACT_ADD  = 2'd2
    } cal_act_e;

endpackage

// File: rtl/cal_spreader.sv
// Even-spreading correction scheduler.
// An accumulator of WIN_BITS bits adds the magnitude on every raw tick.
// Each carry out marks one tick for correction, so M corrections fall
// evenly across 2^WIN_BITS ticks.
// Assumes tick_in is a one-clock strobe and MAG_W <= WIN_BITS.
module cal_spreader #(
    parameter int WIN_BITS = 20,
    parameter int MAG_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic [MAG_W-1:0] mag,
    output logic             fire
);
    localparam int SUM_W = WIN_BITS + 1;

    logic [WIN_BITS-1:0] acc_q;
    logic [WIN_BITS-1:0] mag_ext;
    logic [SUM_W-1:0]    sum;

    // Widen the magnitude to the accumulator width.
    generate
        if (WIN_BITS > MAG_W) begin : g_pad
            assign mag_ext = {{(WIN_BITS-MAG_W){1'b0}}, mag};
        end else begin : g_cut
            assign mag_ext = mag[WIN_BITS-1:0];
        end
    endgenerate

    // Next accumulator value with its carry.
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, mag_ext};
        fire = tick_in & sum[WIN_BITS];
    end

    // Advance the accumulator once per raw tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (tick_in) begin
            acc_q <= sum[WIN_BITS-1:0];
        end
    end

    // The accumulator moves only on raw ticks (R5).
    assert_acc_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(acc_q));

endmodule

// File: rtl/cal_gap_timer.sv
// Tick interval meter and insertion scheduler.
// Counts clocks between raw ticks. When asked to insert, it emits one
// single-cycle pulse half an interval after the current tick.
// Assumes ticks are at least four clocks apart; the counter saturates.
module cal_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic arm,
    output logic ins_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] gap_q;
    logic [CNT_W-1:0] wait_q;
    logic [CNT_W:0]   period;
    logic [CNT_W-1:0] half;

    // Interval just ended, and half of it.
    always_comb begin
        period = {1'b0, gap_q} + 1'b1;
        half   = period[CNT_W:1];
    end

    // Clocks since the last raw tick, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (tick_in) begin
            gap_q <= '0;
        end else if (gap_q != CNT_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Countdown to the inserted pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (tick_in && arm) begin
            wait_q <= half;
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    assign ins_pulse = (wait_q == {{(CNT_W-1){1'b0}}, 1'b1});

    // An armed countdown is never left pending (R4).
    assert_wait_counts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && wait_q != '0) |=> wait_q == $past(wait_q) - 1'b1);

endmodule

// File: rtl/cal_ref_div.sv
// Reference square-wave divider.
// Counts raw ticks and exposes the counter MSB as the calibration wave.
// Assumes tick_in is the uncorrected strobe.
module cal_ref_div #(
    parameter int REF_DIV_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic wave
);
    logic [REF_DIV_W-1:0] div_q;

    // Count raw ticks modulo 2^REF_DIV_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick_in) begin
            div_q <= div_q + 1'b1;
        end
    end

    assign wave = div_q[REF_DIV_W-1];

    // The wave changes only after a raw tick (R8).
    assert_wave_steps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(wave));

endmodule

// File: rtl/cal_trim_top.sv
// Digital clock calibration adjuster, top level.
// Deletes or inserts ticks of a 32.768 kHz strobe, spread across a window,
// and muxes the shared pin between power-fail and the reference wave.
// Assumes tick_in is synchronous to clk, one clock wide, and spaced by
// at least four clocks.
module cal_trim_top #(
    parameter int WIN_BITS  = 20,
    parameter int MAG_W     = 5,
    parameter int CNT_W     = 16,
    parameter int REF_DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_en,
    input  logic             cal_sign,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             pf_in,
    input  logic             tick_in,
    output logic             tick_out,
    output logic             pin_out
);
    import cal_pkg::*;

    logic     fire;
    logic     ins_pulse;
    logic     ref_wave;
    cal_act_e act;

    cal_spreader #(.WIN_BITS(WIN_BITS), .MAG_W(MAG_W)) i_spread (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .mag(cal_mag), .fire(fire)
    );

    cal_gap_timer #(.CNT_W(CNT_W)) i_gap (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .arm(act == ACT_ADD), .ins_pulse(ins_pulse)
    );

    cal_ref_div #(.REF_DIV_W(REF_DIV_W)) i_ref (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wave(ref_wave)
    );

    // Decide what happens to the current raw tick.
    always_comb begin
        if (!fire)         act = ACT_PASS;
        else if (cal_sign) act = ACT_DROP;
        else               act = ACT_ADD;
    end

    // Register the corrected strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_out <= 1'b0;
        end else begin
            tick_out <= (tick_in && act != ACT_DROP) || ins_pulse;
        end
    end

    // Shared pin selection.
    assign pin_out = cal_en ? ref_wave : pf_in;

    // A deleted tick never reaches the output (R3).
    assert_drop_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && act == ACT_DROP && !ins_pulse) |=> !tick_out);

    // A passed tick shows up one clock later (R2).
    assert_pass_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && act != ACT_DROP) |=> tick_out);

    // Output pulses are one clock wide (R9).
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_out) |=> !tick_out);

endmodule

// File: tb/test_cal_trim_top.sv
module test_cal_trim_top;
    localparam int WIN_BITS  = 6;
    localparam int MAG_W     = 5;
    localparam int CNT_W     = 8;
    localparam int REF_DIV_W = 6;
    localparam int WIN       = 1 << WIN_BITS;
    localparam int GAP       = 10;
    localparam int NVEC      = 8;
    // {sign, magnitude}
    localparam logic [5:0] VEC [NVEC] = '{
        {1'b1, 5'd0}, {1'b0, 5'd0}, {1'b1, 5'd1}, {1'b0, 5'd1},
        {1'b1, 5'd31}, {1'b0, 5'd31}, {1'b1, 5'd10}, {1'b0, 5'd7}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cal_en = 1'b0;
    logic             cal_sign = 1'b0;
    logic [MAG_W-1:0] cal_mag = '0;
    logic             pf_in = 1'b0;
    logic             tick_in = 1'b0;
    logic             tick_out;
    logic             pin_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cal_trim_top #(.WIN_BITS(WIN_BITS), .MAG_W(MAG_W), .CNT_W(CNT_W),
                   .REF_DIV_W(REF_DIV_W)) i_cal_trim_top (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .cal_sign(cal_sign),
        .cal_mag(cal_mag), .pf_in(pf_in), .tick_in(tick_in),
        .tick_out(tick_out), .pin_out(pin_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        tick_in = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // One raw tick, then GAP-1 idle clocks; returns number of out pulses
    // and number of mismatches with the expected placement.
    task automatic one_tick(input bit drop, input bit add,
                            inout int outs, inout int miss);
        @(negedge clk) tick_in = 1'b1;
        for (int off = 1; off < GAP; off++) begin
            @(negedge clk);
            if (off == 1) tick_in = 1'b0;
            if (tick_out) outs++;
            if (off == 1) begin
                if (tick_out !== !drop) miss++;
            end else if (off == GAP / 2 + 1) begin
                if (tick_out !== add) miss++;
            end else if (tick_out !== 1'b0) begin
                miss++;
            end
        end
    endtask

    task automatic run_vec(input bit sgn, input int mag);
        int outs = 0;
        int miss = 0;
        cal_sign = sgn;
        cal_mag = mag[MAG_W-1:0];
        do_reset();
        for (int n = 1; n <= WIN; n++) begin
            bit fire = ((n * mag) / WIN) > (((n - 1) * mag) / WIN);
            one_tick(fire && sgn, fire && !sgn, outs, miss);
        end
        // R5 spreading, R3 delete, R4 insert, R2 pass, R9 width
        if (mag == 0)  check("R2 pass placement", miss, 0);
        else if (sgn)  check("R3/R5 delete placement", miss, 0);
        else           check("R4/R5 insert placement", miss, 0);
        check("R6 window count", outs, sgn ? WIN - mag : WIN + mag);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        cal_en = 1'b1;
        check("R1 tick_out in reset", int'(tick_out), 0);
        check("R1 pin in reset", int'(pin_out), 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick_out after reset", int'(tick_out), 0);

        for (int v = 0; v < NVEC; v++) run_vec(VEC[v][5], int'(VEC[v][4:0]));

        // R7 pin passthrough
        cal_en = 1'b0;
        pf_in = 1'b1;
        #1 check("R7 pin follows pf high", int'(pin_out), 1);
        pf_in = 1'b0;
        #1 check("R7 pin follows pf low", int'(pin_out), 0);

        // R8 reference square wave from raw ticks, deleting to show rawness
        cal_en = 1'b1;
        cal_sign = 1'b1;
        cal_mag = 5'd31;
        do_reset();
        begin
            int o = 0;
            int m = 0;
            for (int n = 1; n <= WIN / 2 - 1; n++) one_tick(1'b0, 1'b0, o, m);
            check("R8 wave low before half", int'(pin_out), 0);
            one_tick(1'b0, 1'b0, o, m);
            check("R8 wave high at half", int'(pin_out), 1);
            pf_in = 1'b0;
            for (int n = 1; n <= WIN / 2; n++) one_tick(1'b0, 1'b0, o, m);
            check("R8 wave low after full period", int'(pin_out), 0);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule